// File: doc/BRIEF.md
# Burst-Locked Manchester Bit Decoder

This block sits on the isolated side of a gate-driver link. It decodes the downstream Manchester stream recovered from the supply transformer winding, after a Schmitt-trigger input stage. The stream comes in bursts that fill most of each power period. Each burst is followed by a short quiet window with no switching, and during that window the return path is free for upstream traffic.

At the first rising edge of each burst, the decoder starts a free-running local bit clock. It does not re-align that clock again until the burst is over. Each bit is recovered by XOR of the synchronised line with the local clock, sampled three quarters of the way through the bit, and delivered with a one-cycle strobe and its index inside the burst. When the line has been silent for one and a half bit times, the decoder reports that the return window has opened. It then waits for the next burst's first rising edge. Parameters set the system-clock cycles per bit (a multiple of 4, at least 8) and the index width.

Top module: `mdec_burst_decoder`

## Requirements
- R1: While reset is asserted, and until the first rising edge after release, `bit_vld`, `win_start` and `locked` are low, whatever the line does.
- R2: The line passes through a two-flop synchroniser. A rising edge sampled at clock edge n while unlocked sets `locked` at clock edge n+2. That cycle (edge n+1 to n+2) is phase 0 of the first bit.
- R3: Bit j of a burst is sampled at phase 3·B/4 of that bit, where B is cycles per bit. Its strobe `bit_vld` is high for exactly the one cycle after clock edge n+2+3·B/4+j·B.
- R4: The local clock is 0 in the first half of each bit and 1 in the second half. `bit_data` is the line XOR that clock, so a bit is 1 when the line is high in its first half and low in its second half, and 0 for the reverse.
- R5: Rising edges seen while locked do not move the local bit clock. The strobe times of R3 hold through the whole burst.
- R6: A strobe is given only for a bit whose phase window [B/4, 3·B/4) contains a line transition. A partial bit at the end of a burst gives no strobe.
- R7: `bit_idx` is the position of the strobed bit inside its burst, counted from 0. The count restarts at every new lock.
- R8: Take the clock edge at which the last line transition of a burst is sampled, and add 2 edges for synchronisation plus 3·B/2 silent cycles. At that edge `win_start` goes high for one cycle and `locked` falls. The next rising edge then locks again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous line level from the winding comparator |
| bit_vld | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Decoded bit value, valid with `bit_vld` |
| bit_idx | output | IDX_W | Position of the strobed bit inside its burst |
| win_start | output | 1 | One-cycle pulse when the return window opens |
| locked | output | 1 | High while the local bit clock runs for a burst |

## Verification
The checker examines every cycle for a few things. Strobes and window pulses must last one cycle, strobes may come only while locked, the window pulse must coincide with the loss of lock, and each strobe's index must follow the previous one or restart at 0 after a lock. The exact position of each strobe relative to the first rising edge, the decoded values, and the suppression of a truncated final bit can only be shown by the bench's scenarios. So can the exact cycle at which the window opens after the last transition. The bench sweeps many burst patterns, lengths, tails and gaps.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } mdec_state_e;
endpackage

// File: rtl/mdec_sync_edge.sv
module mdec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_s,
  output logic rise,
  output logic toggle
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = line_async;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_s = chain_q[STAGES-1];
  assign rise   = line_s & ~prev_q;
  assign toggle = line_s ^ prev_q;
endmodule

// File: rtl/mdec_bit_timer.sv
module mdec_bit_timer #(
  parameter int BIT_CYC = 40,
  parameter int PH_W    = $clog2(BIT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic wrap,
  output logic clk_loc,
  output logic mid_win,
  output logic at_sample
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);
  localparam logic [PH_W-1:0] PH_QTR  = PH_W'(BIT_CYC / 4);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(BIT_CYC / 2);
  localparam logic [PH_W-1:0] PH_SAMP = PH_W'((3 * BIT_CYC) / 4);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic            phase_en;

  always_comb begin
    phase_en = restart | run;
    phase_d  = phase_q;
    if (restart) begin
      phase_d = PH_W'(1);
    end else if (run) begin
      phase_d = (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign wrap      = (phase_q == PH_LAST);
  assign clk_loc   = (phase_q >= PH_HALF);
  assign mid_win   = (phase_q >= PH_QTR) && (phase_q < PH_SAMP);
  assign at_sample = (phase_q == PH_SAMP);
endmodule

// File: rtl/mdec_quiet_watch.sv
module mdec_quiet_watch #(
  parameter int LIMIT = 60,
  parameter int Q_W   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  input  logic toggle,
  output logic expired
);
  localparam logic [Q_W-1:0] Q_LIM = Q_W'(LIMIT);

  logic [Q_W-1:0] cnt_q;
  logic [Q_W-1:0] cnt_d;
  logic [Q_W-1:0] cur;

  always_comb begin
    cur = toggle ? '0 : cnt_q;
    if (!arm) begin
      cnt_d = '0;
    end else if (cur == Q_LIM) begin
      cnt_d = cur;
    end else begin
      cnt_d = cur + Q_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cur == Q_LIM);
endmodule

// File: rtl/mdec_burst_decoder.sv
module mdec_burst_decoder #(
  parameter int BIT_CYC = 40,
  parameter int IDX_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             bit_vld,
  output logic             bit_data,
  output logic [IDX_W-1:0] bit_idx,
  output logic             win_start,
  output logic             locked
);
  import mdec_pkg::*;

  localparam int SYNC_STAGES = 2;
  localparam int QUIET_LIM   = (3 * BIT_CYC) / 2;

  mdec_state_e      state_q, state_d;
  logic             line_s, rise, toggle;
  logic             wrap, clk_loc, mid_win, at_sample;
  logic             expired;
  logic             tracking, rise_hunt;
  logic             mid_q, mid_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             strobe;
  logic             vld_q, data_q, win_q;
  logic             data_d;
  logic [IDX_W-1:0] idx_q;

  mdec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_async (line_in),
    .line_s     (line_s),
    .rise       (rise),
    .toggle     (toggle)
  );

  assign tracking  = (state_q == ST_TRACK);
  assign rise_hunt = ~tracking & rise;

  mdec_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (rise_hunt),
    .run       (tracking),
    .wrap      (wrap),
    .clk_loc   (clk_loc),
    .mid_win   (mid_win),
    .at_sample (at_sample)
  );

  mdec_quiet_watch #(.LIMIT(QUIET_LIM)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (tracking | rise_hunt),
    .run     (tracking),
    .toggle  (toggle),
    .expired (expired)
  );

  // Lock state: hunt for a rising edge, track until the line falls silent.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:  if (rise)    state_d = ST_TRACK;
      ST_TRACK: if (expired) state_d = ST_HUNT;
      default:  state_d = ST_HUNT;
    endcase
  end

  // Bit qualification, sampling and indexing.
  always_comb begin
    mid_d = mid_q;
    if (rise_hunt || !tracking) begin
      mid_d = 1'b0;
    end else if (wrap) begin
      mid_d = 1'b0;
    end else if (toggle && mid_win) begin
      mid_d = 1'b1;
    end

    strobe = tracking & at_sample & mid_q & ~expired;
    data_d = line_s ^ clk_loc;

    cnt_d = cnt_q;
    if (rise_hunt) begin
      cnt_d = '0;
    end else if (strobe) begin
      cnt_d = cnt_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      mid_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mid_q   <= mid_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      win_q <= 1'b0;
    end else begin
      vld_q <= strobe;
      win_q <= tracking & expired;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      idx_q  <= '0;
    end else if (strobe) begin
      data_q <= data_d;
      idx_q  <= cnt_q;
    end
  end

  assign bit_vld   = vld_q;
  assign bit_data  = data_q;
  assign bit_idx   = idx_q;
  assign win_start = win_q;
  assign locked    = tracking;
endmodule

// File: rtl/mdec_burst_checker.sv
module mdec_burst_checker #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic [IDX_W-1:0] bit_idx,
  input logic             win_start,
  input logic             locked
);
  logic             have_prev;
  logic [IDX_W-1:0] prev_idx;
  logic [IDX_W-1:0] next_idx;

  assign next_idx = prev_idx + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else if (win_start) begin
      have_prev <= 1'b0;
    end else if (bit_vld) begin
      have_prev <= 1'b1;
      prev_idx  <= bit_idx;
    end
  end

  AST_WIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !win_start); // R8
  AST_WIN_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> !locked); // R8
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld); // R6
  AST_VLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(locked)); // R3
  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !have_prev) |-> (bit_idx == '0)); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && have_prev) |-> (bit_idx == next_idx)); // R7
endmodule

bind mdec_burst_decoder mdec_burst_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .bit_idx   (bit_idx),
  .win_start (win_start),
  .locked    (locked)
);

// File: tb/sim_mdec_burst_decoder.sv
module sim_mdec_burst_decoder;
  localparam int B    = 16;
  localparam int S    = (3 * B) / 4;
  localparam int L    = (3 * B) / 2;
  localparam int IW   = 4;
  localparam int STUB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_in;
  logic          bit_vld, bit_data, win_start, locked;
  logic [IW-1:0] bit_idx;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  int       cur_n0 = -100000;
  int       cur_n = 0;
  int       cur_tlast = -100000;
  logic [7:0] cur_bits = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdec_burst_decoder #(.BIT_CYC(B), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bit_vld(bit_vld), .bit_data(bit_data), .bit_idx(bit_idx),
    .win_start(win_start), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison against expectations derived from the requirements.
  always @(negedge clk) begin
    if (mon_en) begin
      bit exp_vld;
      bit exp_d;
      int exp_i;
      bit exp_win;
      bit exp_lock;
      exp_vld = 1'b0; exp_d = 1'b0; exp_i = 0;
      for (int j = 0; j < cur_n; j++) begin
        if (cyc == cur_n0 + 2 + S + j * B) begin
          exp_vld = 1'b1; exp_d = cur_bits[j]; exp_i = j;
        end
      end
      exp_win  = (cyc == cur_tlast + 2 + L);
      exp_lock = (cyc >= cur_n0 + 2) && (cyc < cur_tlast + 2 + L);
      chk(bit_vld == exp_vld, "R3 R5 R6 strobe", int'(bit_vld), int'(exp_vld));
      if (exp_vld) begin
        chk(bit_data == exp_d, "R4 data", int'(bit_data), int'(exp_d));
        chk(int'(bit_idx) == (exp_i % (1 << IW)), "R7 index", int'(bit_idx), exp_i);
      end
      chk(win_start == exp_win, "R8 window", int'(win_start), int'(exp_win));
      chk(locked == exp_lock, "R2 lock", int'(locked), int'(exp_lock));
    end
  end

  task automatic drive(input logic v);
    @(negedge clk);
    line_in = v;
  endtask

  initial begin
    rst_n   = 1'b0;
    line_in = 1'b0;
    // R1: line activity under reset has no effect.
    for (int i = 0; i < 6; i++) drive(i[0]);
    @(negedge clk);
    chk(!bit_vld, "R1 reset vld", int'(bit_vld), 0);
    chk(!win_start, "R1 reset win", int'(win_start), 0);
    chk(!locked, "R1 reset lock", int'(locked), 0);
    line_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0);
    chk(!locked && !bit_vld, "R1 idle after release", int'(locked), 0);
    mon_en = 1'b1;

    for (int k = 0; k < 64; k++) begin
      int         nb;
      bit         stub;
      int         gap;
      logic [7:0] b;
      nb   = 4 + (k % 4);
      stub = ((k % 5) == 3);
      gap  = L + 6 + (k % 3) * 5;
      b    = '0;
      b[0] = 1'b1;
      for (int j = 1; j < nb; j++) b[j] = k[j-1];
      for (int j = 0; j < nb; j++) begin
        for (int x = 0; x < B; x++) begin
          @(negedge clk);
          if (j == 0 && x == 0) begin
            cur_n0   = cyc + 1;
            cur_n    = nb;
            cur_bits = b;
            if (stub)            cur_tlast = cur_n0 + nb * B + STUB;
            else if (!b[nb-1])   cur_tlast = cur_n0 + nb * B;
            else                 cur_tlast = cur_n0 + (nb - 1) * B + B / 2;
          end
          line_in = (x < B / 2) ? b[j] : ~b[j];
        end
      end
      if (stub) begin
        // R6: a truncated bit with no mid-bit transition is discarded.
        for (int x = 0; x < STUB; x++) drive(1'b1);
      end
      for (int x = 0; x < gap; x++) drive(1'b0);
    end
    for (int x = 0; x < L + 10; x++) drive(1'b0);
    mon_en = 1'b0;
    done   = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule